// File: doc/BRIEF.md
# Initialization Address and Bank Pattern Driver

This block sits next to a DRAM memory controller while the memory is being brought up. It holds a 13-bit row/column address pattern and a 2-bit bank pattern written by the host, and drives them onto the memory's address and bank lines. It also controls a switch-enable line for a set of bus isolation switches. While those switches are open, the memory controller is cut off and this block owns the lines. The host can therefore present any mode-register value it needs, including patterns the controller cannot produce by itself.

The host reaches the block through a byte-wide I/O port decode with a window of eight consecutive byte addresses starting at `BASE_ADDR`. Offset 0 holds the low address byte. Offset 1 holds three things: the upper address bits, the bank bits and a close command. After the last pattern, the host writes the close command. The switches then close, the block floats its address and bank drivers, and the memory controller takes the lines over.

The DRAM clock-enable signal is the block's active-low reset. While clock-enable is low, the block returns to its open, all-zero state.

Top module: `init_pattern_driver`

## Requirements
- R1: While `dramCke` is low, the pattern registers are zero, the close flag is cleared, `switchOpen` is 1 and `addrDrvEn` is 1. The reset is asynchronous, and it is visible at the ports by the first clock edge at the latest.
- R2: A write to offset 0 loads `ioWdata[7:0]` into `addrOut[7:0]`. The new value appears after the next rising clock edge.
- R3: A write to offset 1 loads two fields after the next rising clock edge: `ioWdata[4:0]` goes to `addrOut[12:8]` and `ioWdata[6:5]` goes to `bankOut[1:0]`.
- R4: A write to offset 1 with `ioWdata[7]` = 1 closes the switches. After the next rising clock edge, `switchOpen` is 0 and `addrDrvEn` is 0. A write with bit 7 = 0 while the switches are open leaves them open.
- R5: Once closed, the switches stay closed until `dramCke` goes low. A later write with bit 7 = 0 does not reopen them.
- R6: Reads are combinational in the same cycle. Offset 0 returns `addrOut[7:0]`. Offset 1 returns {close flag in bit 7, bank in bits 6:5, `addrOut[12:8]` in bits 4:0}.
- R7: `ioHit` is 1 for a read or write at any offset 0 to 7. Offsets 2 to 7 read as 0x00, and writes to them change nothing.
- R8: An access outside the window gives `ioHit` = 0 and `ioRdata` = 0x00, and a write there changes no output.
- R9: Pattern writes after closing still update the pattern registers. They can be seen through reads, even though the drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| dramCke | input | 1 | DRAM clock-enable, used as the active-low asynchronous reset |
| ioAddr | input | 16 | Host I/O byte address |
| ioWrite | input | 1 | Host write strobe for the current cycle |
| ioRead | input | 1 | Host read strobe for the current cycle |
| ioWdata | input | 8 | Host write data |
| ioRdata | output | 8 | Read data for a claimed read, zero otherwise |
| ioHit | output | 1 | Access falls in the block's eight-byte window |
| addrOut | output | 13 | Address pattern to the DRAM address lines |
| bankOut | output | 2 | Bank pattern to the DRAM bank lines |
| addrDrvEn | output | 1 | Output enable for the address and bank drivers; 0 means high impedance |
| switchOpen | output | 1 | Isolation switch control; 1 keeps the memory controller disconnected |

## Verification
A wrong internal state shows at the pins one clock edge after the write that caused it. A misrouted field appears on `addrOut` or `bankOut`, and a close flag that is lost or set by mistake appears on `switchOpen` and `addrDrvEn`. A hidden corruption of the stored pattern while the switches are closed appears only on the next read of offset 0 or 1, in the same cycle as that read. Decoding faults show in the read cycle itself: `ioHit` or `ioRdata` is wrong for an unused offset or for an address outside the window.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
  // Strobes from the decoder to the pattern datapath
  typedef struct packed {
    logic wrLo;   // write low address byte
    logic wrHi;   // write high address bits, bank and close command
    logic rdLo;   // select low byte for readback
    logic rdHi;   // select high byte for readback
  } ctrlStrobe_t;
endpackage

// File: rtl/mrp_ctrl.sv
module mrp_ctrl
  import mrp_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] BASE_ADDR = 16'h0300,
  parameter int WINDOW_BYTES = 8
) (
  input  logic [IO_AW-1:0] ioAddr,
  input  logic             ioWrite,
  input  logic             ioRead,
  output logic             ioHit,
  output ctrlStrobe_t      strobe
);
  localparam logic [IO_AW-1:0] WIN_LIMIT = IO_AW'(WINDOW_BYTES);
  localparam logic [IO_AW-1:0] OFF_LO    = IO_AW'(0);
  localparam logic [IO_AW-1:0] OFF_HI    = IO_AW'(1);

  logic [IO_AW-1:0] offset;
  logic             inWindow;

  always_comb begin
    offset   = ioAddr - BASE_ADDR;
    inWindow = (offset < WIN_LIMIT);
    ioHit    = inWindow && (ioRead || ioWrite);

    strobe.wrLo = ioWrite && inWindow && (offset == OFF_LO);
    strobe.wrHi = ioWrite && inWindow && (offset == OFF_HI);
    strobe.rdLo = ioRead  && inWindow && (offset == OFF_LO);
    strobe.rdHi = ioRead  && inWindow && (offset == OFF_HI);
  end
endmodule

// File: rtl/mrp_datapath.sv
module mrp_datapath
  import mrp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [BYTE_W-1:0] wdata,
  output logic [ADDR_W-1:0] addrPat,
  output logic [BANK_W-1:0] bankPat,
  output logic              closed,
  output logic [BYTE_W-1:0] rdata
);
  localparam int HI_W    = ADDR_W - BYTE_W;
  localparam int BANK_LO = HI_W;
  localparam int CLOSE_B = BYTE_W - 1;

  logic [BYTE_W-1:0] addrLo;
  logic [HI_W-1:0]   addrHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo  <= '0;
      addrHi  <= '0;
      bankPat <= '0;
      closed  <= 1'b0;
    end else begin
      if (strobe.wrLo) addrLo <= wdata;
      if (strobe.wrHi) begin
        addrHi  <= wdata[HI_W-1:0];
        bankPat <= wdata[BANK_LO+BANK_W-1:BANK_LO];
        closed  <= closed | wdata[CLOSE_B];   // sticky until reset
      end
    end
  end

  assign addrPat = {addrHi, addrLo};

  always_comb begin
    rdata = '0;
    if (strobe.rdLo)      rdata = addrLo;
    else if (strobe.rdHi) rdata = {closed, bankPat, addrHi};
  end
endmodule

// File: rtl/init_pattern_driver.sv
module init_pattern_driver
  import mrp_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] BASE_ADDR = 16'h0300,
  parameter int WINDOW_BYTES = 8,
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              dramCke,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic              ioWrite,
  input  logic              ioRead,
  input  logic [BYTE_W-1:0] ioWdata,
  output logic [BYTE_W-1:0] ioRdata,
  output logic              ioHit,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BANK_W-1:0] bankOut,
  output logic              addrDrvEn,
  output logic              switchOpen
);
  ctrlStrobe_t strobe;
  logic        closed;

  mrp_ctrl #(
    .IO_AW(IO_AW), .BASE_ADDR(BASE_ADDR), .WINDOW_BYTES(WINDOW_BYTES)
  ) u_ctrl (
    .ioAddr(ioAddr), .ioWrite(ioWrite), .ioRead(ioRead),
    .ioHit(ioHit), .strobe(strobe)
  );

  mrp_datapath #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(dramCke), .strobe(strobe), .wdata(ioWdata),
    .addrPat(addrOut), .bankPat(bankOut), .closed(closed), .rdata(ioRdata)
  );

  // Switches open and drivers active until the host closes them
  assign switchOpen = !closed;
  assign addrDrvEn  = !closed;
endmodule

// File: rtl/mrp_checker.sv
module mrp_checker #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] BASE_ADDR = 16'h0300,
  parameter int WINDOW_BYTES = 8
) (
  input logic             clk,
  input logic             dramCke,
  input logic [IO_AW-1:0] ioAddr,
  input logic             ioWrite,
  input logic             ioRead,
  input logic [7:0]       ioWdata,
  input logic [7:0]       ioRdata,
  input logic [12:0]      addrOut,
  input logic [1:0]       bankOut,
  input logic             addrDrvEn,
  input logic             switchOpen
);
  logic [IO_AW-1:0] chkOff;
  logic             chkInside;
  assign chkOff    = ioAddr - BASE_ADDR;
  assign chkInside = chkOff < IO_AW'(WINDOW_BYTES);

  a_r1_reset_state: assert property (@(posedge clk)
    !dramCke |=> (switchOpen && addrDrvEn && addrOut == '0 && bankOut == '0));

  a_r2_low_byte: assert property (@(posedge clk) disable iff (!dramCke)
    (ioWrite && chkInside && chkOff == IO_AW'(0)) |=> addrOut[7:0] == $past(ioWdata));

  a_r4_close: assert property (@(posedge clk) disable iff (!dramCke)
    (ioWrite && chkInside && chkOff == IO_AW'(1) && ioWdata[7]) |=> (!switchOpen && !addrDrvEn));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!dramCke)
    !switchOpen |=> !switchOpen);

  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!dramCke)
    (ioRead && chkInside && chkOff > IO_AW'(1)) |-> ioRdata == 8'h00);

  a_r8_outside: assert property (@(posedge clk) disable iff (!dramCke)
    (ioWrite && !chkInside) |=> ($stable(addrOut) && $stable(bankOut) && $stable(switchOpen)));
endmodule

bind init_pattern_driver mrp_checker #(
  .IO_AW(IO_AW), .BASE_ADDR(BASE_ADDR), .WINDOW_BYTES(WINDOW_BYTES)
) u_chk (
  .clk(clk), .dramCke(dramCke), .ioAddr(ioAddr), .ioWrite(ioWrite),
  .ioRead(ioRead), .ioWdata(ioWdata), .ioRdata(ioRdata), .addrOut(addrOut),
  .bankOut(bankOut), .addrDrvEn(addrDrvEn), .switchOpen(switchOpen)
);

// File: tb/init_pattern_driver_tb.sv
module init_pattern_driver_tb;
  localparam logic [15:0] BASE = 16'h0300;

  logic        clk = 1'b0;
  logic        dramCke = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWrite = 1'b0, ioRead = 1'b0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  ioRdata;
  logic        ioHit;
  logic [12:0] addrOut;
  logic [1:0]  bankOut;
  logic        addrDrvEn, switchOpen;

  always #5 clk = ~clk;

  init_pattern_driver #(.BASE_ADDR(BASE)) u_dut (
    .clk(clk), .dramCke(dramCke), .ioAddr(ioAddr), .ioWrite(ioWrite),
    .ioRead(ioRead), .ioWdata(ioWdata), .ioRdata(ioRdata), .ioHit(ioHit),
    .addrOut(addrOut), .bankOut(bankOut), .addrDrvEn(addrDrvEn),
    .switchOpen(switchOpen)
  );

  typedef struct {
    string       req;
    logic        chkRd;
    logic [7:0]  rd;
    logic [12:0] a;
    logic [1:0]  b;
    logic        open;
    logic        hit;
  } exp_t;

  exp_t expQ[$];
  int   total = 0, fails = 0;
  bit   finished = 0;

  // Reference model, built from the requirements
  logic [7:0] mLo = '0;
  logic [4:0] mHi = '0;
  logic [1:0] mBank = '0;
  logic       mClosed = 1'b0;

  function automatic exp_t snapshot(string req, logic chkRd, logic [7:0] rd, logic hit);
    exp_t e;
    e.req = req; e.chkRd = chkRd; e.rd = rd; e.hit = hit;
    e.a = {mHi, mLo}; e.b = mBank; e.open = !mClosed;
    return e;
  endfunction

  task automatic access(input logic wr, input logic rd, input logic [15:0] a,
                        input logic [7:0] d, input string req);
    logic [15:0] off;
    logic        inWin;
    logic [7:0]  expRd;
    @(negedge clk);
    ioAddr = a; ioWrite = wr; ioRead = rd; ioWdata = d;
    off   = a - BASE;
    inWin = off < 16'd8;
    expRd = 8'h00;
    if (rd && inWin && off == 16'd0) expRd = mLo;
    if (rd && inWin && off == 16'd1) expRd = {mClosed, mBank, mHi};
    if (wr && inWin && off == 16'd0) mLo = d;
    if (wr && inWin && off == 16'd1) begin
      mHi = d[4:0]; mBank = d[6:5]; mClosed = mClosed | d[7];
    end
    expQ.push_back(snapshot(req, rd, expRd, inWin && (wr || rd)));
    @(negedge clk);
    ioWrite = 1'b0; ioRead = 1'b0;
  endtask

  task automatic resetPulse(input string req);
    @(negedge clk);
    dramCke = 1'b0;
    mLo = '0; mHi = '0; mBank = '0; mClosed = 1'b0;
    expQ.push_back(snapshot(req, 1'b0, 8'h00, 1'b0));
    @(negedge clk);
    dramCke = 1'b1;
  endtask

  // Monitor: compares the outputs shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0 && !finished) begin
      exp_t e;
      e = expQ.pop_front();
      total++;
      if (addrOut !== e.a || bankOut !== e.b || switchOpen !== e.open ||
          addrDrvEn !== e.open || ioHit !== e.hit || (e.chkRd && ioRdata !== e.rd)) begin
        fails++;
        $display("FAIL %s: addr=%h bank=%h open=%b oe=%b hit=%b rd=%h expected addr=%h bank=%h open=%b hit=%b rd=%h",
                 e.req, addrOut, bankOut, switchOpen, addrDrvEn, ioHit, ioRdata,
                 e.a, e.b, e.open, e.hit, e.rd);
      end
    end
  end

  task automatic finish();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish();
    end
  end

  initial begin
    resetPulse("R1 reset state");
    access(1, 0, BASE + 16'd0, 8'hA5, "R2 low byte");
    access(0, 1, BASE + 16'd0, 8'h00, "R6 read low");
    access(1, 0, BASE + 16'd1, 8'h7F, "R3 high bits and bank, R4 bit7=0 stays open");
    access(0, 1, BASE + 16'd1, 8'h00, "R6 read high");
    access(1, 0, BASE + 16'd0, 8'h00, "R2 low byte zero");
    access(1, 0, BASE + 16'd1, 8'h25, "R3 bank=1 hi=5");
    access(1, 0, BASE + 16'd3, 8'hFF, "R7 unused write ignored");
    access(0, 1, BASE + 16'd3, 8'h00, "R7 unused read zero");
    access(0, 1, BASE + 16'd7, 8'h00, "R7 top of window");
    access(1, 0, BASE + 16'd8, 8'h12, "R8 write above window");
    access(1, 0, BASE - 16'd1, 8'hE3, "R8 write below window");
    access(0, 1, BASE + 16'd8, 8'h00, "R8 read outside");
    access(1, 0, BASE + 16'd1, 8'h80, "R4 close switches");
    access(1, 0, BASE + 16'd1, 8'h2A, "R5 stays closed, R9 pattern update");
    access(0, 1, BASE + 16'd1, 8'h00, "R9 readback while closed");
    access(1, 0, BASE + 16'd0, 8'h3C, "R9 low byte while closed");
    access(0, 1, BASE + 16'd0, 8'h00, "R9 read low while closed");
    resetPulse("R1 reset reopens");
    access(0, 1, BASE + 16'd1, 8'h00, "R1 cleared high register");
    @(negedge clk);
    @(negedge clk);
    finish();
  end
endmodule